// File: doc/BRIEF.md
# Serial Peripheral Host Controller with Programmable Word Length

The block is a single-word SPI master attached to a small 32-bit register interface. Software writes a mode word, which holds the word length, the SCK rate, the clock polarity and phase, the bit order, loopback and enable. A write to the transmit register then starts a transfer of 4 to 16 or 32 bits. SCK is made from the system clock by a two-step prescaler. It idles at the programmed polarity and is driven only while a word is moving.

Data sits at fixed positions inside the 32-bit data registers, and the bit order decides where. In MSB-first mode the outgoing word is taken from the top of the transmit register. The received word lands with its LSB at bit 16. In LSB-first mode the outgoing word is taken from the bottom of the register. The received word lands with its MSB at bit 15. The transmit side has one holding register in front of the shifter, so software can queue a second word while one is in flight.

Two event flags report progress: receive-ready and transmit-free. Each can be routed to one interrupt line through a mask. A select register drives the active-low device-select pins directly. A read-only capability word describes the build.

Top module: `spi_host_core`

## Requirements
- R1: After reset the mode register reads 0, the event register reads 0x2 (transmit-free set, receive-ready clear), the mask reads 0, the select register and `ss_n` are all ones, and `sck` and `irq` are low.
- R2: The word length is taken from mode bits [3:0]. A value of 0 means 32 bits, and any other value n means n+1 bits, of which 4 to 16 are legal. A transfer produces exactly that many sampling edges on `sck`.
- R3: The SCK period is 4×(P+1) system clocks, where P is mode bits [7:4]. When mode bit 8 is set, the period is 64×(P+1) system clocks.
- R4: `sck` idles at the level of mode bit 10 (polarity). With mode bit 9 (phase) clear, data is sampled on the first edge of each bit. With bit 9 set, data is sampled on the second edge of each bit.
- R5: Mode bit 11 selects MSB-first order. MSB-first sends bits 31 downward from the transmit register. LSB-first sends bits 0 upward.
- R6: Received data is placed at fixed positions. For words of 16 bits or fewer, MSB-first puts the word's LSB at bit 16, and LSB-first puts the word's MSB at bit 15. A 32-bit word fills the whole register. All other bits read 0.
- R7: When mode bit 12 (loopback) is set, the receive input is the block's own serial output and `miso` is ignored.
- R8: The register map is: 0 mode, 1 events, 2 mask, 3 transmit, 4 receive, 5 select, 6 capability. Event bit 0 (receive-ready) is set on the last SCK edge of a word. It is cleared by reading register 4 or by writing 1 to event bit 0. Event bit 1 (transmit-free) clears when a word is accepted and sets again when that word moves into the shifter.
- R9: A transmit write is ignored while mode bit 13 (enable) is 0 or while transmit-free is 0.
- R10: If a second word completes before the first was read, the receive register holds the second word.
- R11: `irq` is high exactly when some event bit is 1 and its mask bit (same position in register 2) is 1.
- R12: Each `ss_n` pin follows its bit in register 5, bit 0 to pin 0.
- R13: Register 6 reads the maximum word length minus one (31) in bits [4:0], a select-present flag in bit 8, and the number of select pins in bits [23:16].
- R14: While enable is 0, `sck` does not toggle and no word is shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears receive-ready on the receive register) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSEL | Active-low device selects |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench runs loopback transfers over random lengths, orders, phases and polarities. It compares the bit sequence seen at the sampling edges of `sck` and the justified receive word against bench models. A design that swapped the edge roles, mis-decoded length field 0, or put data at the wrong offset would show a wrong sequence, a wrong edge count or a shifted value. Directed cases measure the SCK period in both prescaler ranges. They also queue three writes against a busy shifter, where the third must be dropped and the second must overwrite the unread first. A transmit write while disabled must leave the flags and `sck` untouched. The last directed case clears receive-ready by writing 1 and watches the mask gate `irq` at each step.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    localparam int DW    = 32;
    localparam int HALFW = 10;
    localparam int EDGEW = 7;

    typedef enum logic [2:0] {
        A_MODE  = 3'd0,
        A_EVENT = 3'd1,
        A_MASK  = 3'd2,
        A_TX    = 3'd3,
        A_RX    = 3'd4,
        A_SEL   = 3'd5,
        A_CAPS  = 3'd6
    } reg_addr_e;

    // bit 13 down to bit 0
    typedef struct packed {
        logic       en;
        logic       loop;
        logic       msb_first;
        logic       cpol;
        logic       cpha;
        logic       slow;
        logic [3:0] pm;
        logic [3:0] lenf;
    } mode_t;

    localparam int MODEW = $bits(mode_t);

    typedef struct packed {
        logic tx_free;
        logic rx_full;
    } evt_t;

    function automatic logic [5:0] word_bits(input logic [3:0] lenf);
        return (lenf == 4'd0) ? 6'd32 : ({2'b00, lenf} + 6'd1);
    endfunction

    // system clocks per SCK half period
    function automatic logic [HALFW-1:0] half_cycles(input logic slow, input logic [3:0] pm);
        logic [HALFW-1:0] base;
        base = {{(HALFW-4){1'b0}}, pm} + 1'b1;
        return slow ? (base << 5) : (base << 1);
    endfunction

    function automatic logic [DW-1:0] place_rx(input logic [DW-1:0] r, input logic msb, input logic [5:0] bits);
        if (bits == 6'd32) return r;
        return msb ? (r << 16) : (r >> 16);
    endfunction
endpackage

// File: rtl/spi_host_clkgen.sv
module spi_host_clkgen #(
    parameter int W = spi_host_pkg::HALFW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] half,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = run && (cnt == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < half));
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
    import spi_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          start,
    input  logic [DW-1:0] word_in,
    input  mode_t         cfg,
    input  logic          miso,
    output logic          busy,
    output logic          done,
    output logic          sck,
    output logic          mosi,
    output logic [DW-1:0] rx_word
);
    mode_t            act;
    logic [DW-1:0]    tx_sr, rx_sr, rx_next;
    logic [EDGEW-1:0] edge_cnt;
    logic             phase, tick, leading, do_sample, do_shift, last, din;
    logic [5:0]       bits;
    logic [HALFW-1:0] half;

    assign bits = word_bits(act.lenf);
    assign half = half_cycles(act.slow, act.pm);

    spi_host_clkgen #(.W(HALFW)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .run  (busy && en),
        .half (half),
        .tick (tick)
    );

    assign leading   = !edge_cnt[0];
    assign do_sample = act.cpha ? !leading : leading;
    assign do_shift  = act.cpha ? (leading && (edge_cnt != '0)) : !leading;
    assign last      = (edge_cnt == ({bits, 1'b0} - 7'd1));
    assign mosi      = act.msb_first ? tx_sr[DW-1] : tx_sr[0];
    assign din       = act.loop ? mosi : miso;
    assign sck       = busy ? (act.cpol ^ phase) : cfg.cpol;

    always_comb begin
        rx_next = rx_sr;
        if (do_sample)
            rx_next = act.msb_first ? {rx_sr[DW-2:0], din} : {din, rx_sr[DW-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act      <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            rx_word  <= '0;
            edge_cnt <= '0;
            phase    <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                busy  <= 1'b0;
                phase <= 1'b0;
            end else if (!busy) begin
                if (start) begin
                    act      <= cfg;
                    tx_sr    <= word_in;
                    rx_sr    <= '0;
                    edge_cnt <= '0;
                    phase    <= 1'b0;
                    busy     <= 1'b1;
                end
            end else if (tick) begin
                phase    <= ~phase;
                edge_cnt <= edge_cnt + 1'b1;
                rx_sr    <= rx_next;
                if (do_shift)
                    tx_sr <= act.msb_first ? (tx_sr << 1) : (tx_sr >> 1);
                if (last) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    phase   <= 1'b0;
                    rx_word <= place_rx(rx_next, act.msb_first, bits);
                end
            end
        end
    end

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R14
    off_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);
    // R2
    start_go_chk: assert property (@(posedge clk) disable iff (rst)
        (start && en && !busy) |=> busy);
endmodule

// File: rtl/spi_host_core.sv
module spi_host_core
    import spi_host_pkg::*;
#(
    parameter int NSEL = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      reg_addr,
    input  logic            reg_we,
    input  logic            reg_re,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            sck,
    output logic            mosi,
    input  logic            miso,
    output logic [NSEL-1:0] ss_n,
    output logic            irq
);
    localparam logic [4:0] MAXLEN_M1  = 5'(DW - 1);
    localparam logic [7:0] NSEL_W     = 8'(NSEL);
    localparam logic       SS_PRESENT = (NSEL > 0);

    mode_t         mode_q;
    evt_t          ev_q;
    logic [1:0]    ev_bits, mask_q;
    logic [DW-1:0] tx_hold, rx_word;
    logic [NSEL-1:0] sel_q;
    logic          wr_mode, wr_ev, wr_mask, wr_tx, wr_sel, rd_rx;
    logic          tx_accept, start, busy, eng_done;

    assign wr_mode   = reg_we && (reg_addr == A_MODE);
    assign wr_ev     = reg_we && (reg_addr == A_EVENT);
    assign wr_mask   = reg_we && (reg_addr == A_MASK);
    assign wr_tx     = reg_we && (reg_addr == A_TX);
    assign wr_sel    = reg_we && (reg_addr == A_SEL);
    assign rd_rx     = reg_re && (reg_addr == A_RX);
    assign tx_accept = wr_tx && mode_q.en && ev_q.tx_free;
    assign start     = mode_q.en && !ev_q.tx_free && !busy;
    assign ev_bits   = ev_q;
    assign irq       = |(ev_bits & mask_q);
    assign ss_n      = sel_q;

    spi_host_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .en      (mode_q.en),
        .start   (start),
        .word_in (tx_hold),
        .cfg     (mode_q),
        .miso    (miso),
        .busy    (busy),
        .done    (eng_done),
        .sck     (sck),
        .mosi    (mosi),
        .rx_word (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            mask_q  <= '0;
            tx_hold <= '0;
            sel_q   <= '1;
            ev_q    <= '{tx_free: 1'b1, rx_full: 1'b0};
        end else begin
            if (wr_mode) mode_q <= mode_t'(reg_wdata[MODEW-1:0]);
            if (wr_mask) mask_q <= reg_wdata[1:0];
            if (wr_sel)  sel_q  <= reg_wdata[NSEL-1:0];
            if (tx_accept) begin
                tx_hold       <= reg_wdata;
                ev_q.tx_free  <= 1'b0;
            end else if (start) begin
                ev_q.tx_free  <= 1'b1;
            end
            if (eng_done)
                ev_q.rx_full <= 1'b1;
            else if (rd_rx || (wr_ev && reg_wdata[0]))
                ev_q.rx_full <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            A_MODE:  reg_rdata = {{(32-MODEW){1'b0}}, mode_q};
            A_EVENT: reg_rdata = {30'b0, ev_bits};
            A_MASK:  reg_rdata = {30'b0, mask_q};
            A_RX:    reg_rdata = rx_word;
            A_SEL:   reg_rdata = {{(32-NSEL){1'b0}}, sel_q};
            A_CAPS:  reg_rdata = {8'b0, NSEL_W, 7'b0, SS_PRESENT, 3'b0, MAXLEN_M1};
            default: reg_rdata = '0;
        endcase
    end

    // R9
    hold_take_chk: assert property (@(posedge clk) disable iff (rst)
        tx_accept |=> !ev_q.tx_free);
    // R8
    ne_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_q.rx_full) |-> $past(eng_done));
    // R8
    ne_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && !eng_done) |=> !ev_q.rx_full);
    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 2'b00) |-> !irq);
    // R12
    sel_follow_chk: assert property (@(posedge clk) disable iff (rst)
        wr_sel |=> (ss_n == $past(reg_wdata[NSEL-1:0])));
endmodule

// File: tb/sim_spi_host_core.sv
`timescale 1ns/1ps
module sim_spi_host_core;
    localparam int NSEL = 4;

    logic clk = 1'b0;
    logic rst;
    logic [2:0] addr;
    logic we, re, miso;
    logic [31:0] wdata, rdata;
    logic sck, mosi, irq;
    logic [NSEL-1:0] ss_n;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    spi_host_core #(.NSEL(NSEL)) u0 (
        .clk(clk), .rst(rst), .reg_addr(addr), .reg_we(we), .reg_re(re),
        .reg_wdata(wdata), .reg_rdata(rdata), .sck(sck), .mosi(mosi),
        .miso(miso), .ss_n(ss_n), .irq(irq)
    );

    // serial monitor: captures mosi on sampling edges
    logic mcpol = 1'b0, mcpha = 1'b0;
    logic [31:0] cap = '0;
    int capn = 0;
    int sckchg = 0;
    always @(sck) begin
        sckchg++;
        if ((sck != mcpol) == !mcpha) begin
            cap = {cap[30:0], mosi};
            capn++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
        @(negedge clk); re = 1'b0;
    endtask

    function automatic logic [31:0] fmask(input int bits);
        return (bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
    endfunction

    function automatic logic [31:0] place(input logic [31:0] w, input int bits, input logic msb);
        if (bits == 32) return w;
        return msb ? (w << 16) : (w << (16 - bits));
    endfunction

    function automatic logic [31:0] word_of(input logic [31:0] tx, input int bits, input logic msb);
        return msb ? (tx >> (32 - bits)) : (tx & fmask(bits));
    endfunction

    function automatic logic [31:0] seq_of(input logic [31:0] tx, input int bits, input logic msb);
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < bits; i++) s = {s[30:0], msb ? tx[31-i] : tx[i]};
        return s;
    endfunction

    task automatic wait_ne();
        logic [31:0] e;
        for (int g = 0; g < 4000; g++) begin
            rd(3'd1, e);
            if (e[0]) break;
        end
    endtask

    task automatic run_one(input int bits, input logic msb, input logic cpha, input logic cpol,
                           input logic [3:0] pm, input logic slow, input logic loopb,
                           input logic [31:0] tx);
        logic [31:0] m, rx, expw;
        logic [3:0] lenf;
        int n0;
        lenf = (bits == 32) ? 4'd0 : 4'(bits - 1);
        m = {18'b0, 1'b1, loopb, msb, cpol, cpha, slow, pm, lenf};
        mcpol = cpol; mcpha = cpha;
        wr(3'd0, m);
        chk("R4 idle level", {31'b0, sck}, {31'b0, cpol});
        n0 = capn;
        wr(3'd3, tx);
        wait_ne();
        rd(3'd4, rx);
        expw = loopb ? word_of(tx, bits, msb) : (miso ? fmask(bits) : 32'h0);
        chk(loopb ? "R7 R6 loopback rx" : "R6 external rx", rx, place(expw, bits, msb));
        chk("R2 sample edges", 32'(capn - n0), 32'(bits));
        chk("R5 R4 serial order", cap & fmask(bits), seq_of(tx, bits, msb));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        real t0, t1;
        int b, s0;
        rst = 1'b1; addr = '0; we = 1'b0; re = 1'b0; wdata = '0; miso = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R13 reset state
        rd(3'd0, v); chk("R1 mode", v, 32'h0);
        rd(3'd1, v); chk("R1 events", v, 32'h2);
        rd(3'd2, v); chk("R1 mask", v, 32'h0);
        rd(3'd5, v); chk("R1 select", v, 32'hF);
        chk("R1 pins", {27'b0, ss_n, sck}, {27'b0, 4'hF, 1'b0});
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(3'd6, v); chk("R13 caps", v, 32'h0004_011F);

        // R9 / R14 write while disabled
        s0 = sckchg;
        wr(3'd3, 32'hA5A5_1234);
        repeat (60) @(negedge clk);
        rd(3'd1, v); chk("R9 R14 flags unchanged", v, 32'h2);
        chk("R14 sck quiet", 32'(sckchg - s0), 32'h0);

        // random loopback transfers
        void'($urandom(32'h0000_5EED));
        for (int k = 0; k < 24; k++) begin
            int idx;
            idx = int'($urandom % 14);
            b = (idx == 13) ? 32 : idx + 4;
            run_one(b, 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom % 3), 1'b0, 1'b1, $urandom);
        end
        // directed lengths at the edges
        run_one(4, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 32'h9000_0000);
        run_one(16, 1'b0, 1'b1, 1'b1, 4'd1, 1'b0, 1'b1, 32'h0000_8001);
        run_one(32, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 32'hC3A5_0F81);

        // R6 / R7 external input
        miso = 1'b1;
        run_one(12, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 32'h1234_5678);
        run_one(12, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 32'h1234_5678);
        run_one(32, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 32'h0);
        miso = 1'b0;
        run_one(8, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 32'hFF00_0000);
        run_one(8, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 32'h5A00_0000);

        // R3 SCK rates
        mcpol = 1'b0; mcpha = 1'b0;
        wr(3'd0, {18'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 4'd3});
        wr(3'd3, 32'hF000_0000);
        @(posedge sck); t0 = $realtime;
        @(posedge sck); t1 = $realtime;
        chk("R3 period fast", 32'(int'((t1 - t0) / 10.0)), 32'd8);
        wait_ne(); rd(3'd4, v);
        wr(3'd0, {18'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 4'd3});
        wr(3'd3, 32'hF000_0000);
        @(posedge sck); t0 = $realtime;
        @(posedge sck); t1 = $realtime;
        chk("R3 period slow", 32'(int'((t1 - t0) / 10.0)), 32'd64);
        wait_ne(); rd(3'd4, v);

        // R9 / R10 queue, ignored write, overwrite
        wr(3'd0, {18'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd7});
        wr(3'd3, 32'h1100_0000);
        wr(3'd3, 32'h2200_0000);
        rd(3'd1, v); chk("R8 transmit-free low while queued", v & 32'h2, 32'h0);
        wr(3'd3, 32'h3300_0000);
        repeat (200) @(negedge clk);
        rd(3'd4, v); chk("R10 R9 overwrite keeps second", v, 32'h0022_0000);
        repeat (200) @(negedge clk);
        rd(3'd1, v); chk("R9 dropped write sent nothing", v, 32'h2);

        // R8 / R11 clear by write-one and masking
        wr(3'd3, 32'h4400_0000);
        wait_ne();
        #1 chk("R11 masked off", {31'b0, irq}, 32'h0);
        wr(3'd2, 32'h1);
        #1 chk("R11 ready routed", {31'b0, irq}, 32'h1);
        wr(3'd1, 32'h1);
        rd(3'd1, v); chk("R8 write-one clear", v, 32'h2);
        #1 chk("R11 cleared", {31'b0, irq}, 32'h0);
        wr(3'd2, 32'h2);
        #1 chk("R11 free routed", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'h0);

        // R12 select pins
        wr(3'd5, 32'h5);
        #1 chk("R12 pins", {28'b0, ss_n}, 32'h5);
        rd(3'd5, v); chk("R12 readback", v, 32'h5);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule